// File: doc/BRIEF.md
# APB Transfer Master

This block turns a simple local request stream into APB bus cycles for a single slave. A requester presents an address, a direction bit, write data and a chain flag under a valid/ready handshake. The block then runs the bus through its three phases: idle, a one-cycle setup, and an access phase that lasts as long as the slave holds off its ready. When the transfer finishes, the block hands back the slave's read data and error indication with a one-cycle completion pulse.

A transfer whose chain flag is set lets the block take the next request in the same cycle that the slave completes. The next transfer's setup phase then follows the access phase directly, and the select stays high throughout. A transfer without the flag always returns the bus to idle for at least one cycle. All bus outputs come from registered state, and address, direction and write data are driven to zero whenever the bus is idle.

Top module: `apb_xfer_master`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block resets to idle: `bus_sel`, `bus_enable`, `bus_write`, `bus_addr`, `bus_wdata` and `rsp_done` are all 0, and `req_ready` is 1.
- R2: When a request is accepted in idle (`req_valid` and `req_ready` high at a clock edge), the next cycle shows `bus_sel`=1 and `bus_enable`=0 for exactly one cycle. `bus_addr`, `bus_wdata` and `bus_write` carry the request's values, where `bus_write`=1 means write and 0 means read.
- R3: The cycle after setup, `bus_enable` rises with `bus_sel` still high. While `bus_ready` is 0, the block stays in this access phase with address, direction, write data and select unchanged.
- R4: If the access phase completes (`bus_enable` and `bus_ready` both high) and no new request is accepted, the next cycle is idle, with `bus_sel`, `bus_enable`, `bus_write`, `bus_addr` and `bus_wdata` all 0.
- R5: If the completing transfer had `req_more`=1 and `req_valid` is high in the completion cycle, the new request is accepted there. The next cycle is a setup phase with the new values (`bus_sel`=1, `bus_enable`=0), and no idle cycle comes between the two transfers.
- R6: `req_ready` is 1 in idle. In the access phase it is 1 only while `bus_ready` is 1 and the current transfer has `req_more`=1. It is 0 in setup, and a request offered while it is 0 is neither taken nor changes the bus.
- R7: The cycle after an access phase completes, `rsp_done` is 1 for that one cycle, and `rsp_rdata`/`rsp_err` hold the `bus_rdata`/`bus_err` values sampled at completion (`rsp_err`=1 means error, 0 means okay). These outputs keep their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Requester offers a transfer |
| req_ready | output | 1 | Block can take a transfer this cycle |
| req_addr | input | ADDR_W | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_more | input | 1 | Another transfer may follow without an idle cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data of the last completed transfer |
| rsp_err | output | 1 | Error flag of the last completed transfer |
| bus_sel | output | 1 | Slave select |
| bus_enable | output | 1 | Access phase marker |
| bus_addr | output | ADDR_W | Bus address |
| bus_write | output | 1 | Bus direction, 1 = write |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ready | input | 1 | Slave ready, low inserts wait cycles |
| bus_rdata | input | DATA_W | Slave read data |
| bus_err | input | 1 | Slave error, high = error |

## Verification
The bench builds the block with a 16-bit address and the default 32-bit data width. The narrower address shows that the address path follows its own parameter independently of the data path. With these values, full-width data patterns can be told apart from zeroed idle values on every bit. The sequences cover wait runs from zero to twenty cycles, chains with and without waits, and a chain-flagged transfer whose successor arrives late. They also cover an unflagged transfer followed at once by another request, and slave error responses.

// File: rtl/apb_xfer_pkg.sv
package apb_xfer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_e;

    // Whether a new request may be taken in the present cycle.
    function automatic logic may_take(phase_e cur, logic slv_rdy, logic chain_ok);
        logic ok;
        case (cur)
            PH_IDLE:   ok = 1'b1;
            PH_ACCESS: ok = slv_rdy & chain_ok;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Phase sequencing.
    function automatic phase_e phase_next(phase_e cur, logic take, logic slv_rdy);
        phase_e nx;
        case (cur)
            PH_IDLE:   nx = take ? PH_SETUP : PH_IDLE;
            PH_SETUP:  nx = PH_ACCESS;
            PH_ACCESS: begin
                if (!slv_rdy)  nx = PH_ACCESS;
                else if (take) nx = PH_SETUP;
                else           nx = PH_IDLE;
            end
            default:   nx = PH_IDLE;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/apb_xfer_phase.sv
module apb_xfer_phase
    import apb_xfer_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   slv_ready,
    input  logic   chain_ok,
    output phase_e phase,
    output logic   take,
    output logic   req_ready
);

    phase_e phase_q;

    assign req_ready = may_take(phase_q, slv_ready, chain_ok);
    assign take      = req_valid & req_ready;
    assign phase     = phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_next(phase_q, take, slv_ready);
    end

endmodule

// File: rtl/apb_xfer_drive.sv
module apb_xfer_drive
    import apb_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              take,
    input  logic              slv_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_more,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              chain_ok
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic              more;
    } cmd_t;

    localparam cmd_t CMD_ZERO = '0;

    cmd_t cmd_q;
    logic finish_plain;

    assign finish_plain = (phase == PH_ACCESS) && slv_ready && !take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_ZERO;
        end else if (take) begin
            cmd_q.addr  <= req_addr;
            cmd_q.write <= req_write;
            cmd_q.wdata <= req_wdata;
            cmd_q.more  <= req_more;
        end else if (finish_plain) begin
            cmd_q <= CMD_ZERO;
        end
    end

    assign bus_addr  = cmd_q.addr;
    assign bus_write = cmd_q.write;
    assign bus_wdata = cmd_q.wdata;
    assign chain_ok  = cmd_q.more;

endmodule

// File: rtl/apb_xfer_collect.sv
module apb_xfer_collect
    import apb_xfer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              slv_ready,
    input  logic [DATA_W-1:0] slv_rdata,
    input  logic              slv_err,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);

    logic complete;

    assign complete = (phase == PH_ACCESS) && slv_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_done <= complete;
            if (complete) begin
                rsp_rdata <= slv_rdata;
                rsp_err   <= slv_err;
            end
        end
    end

endmodule

// File: rtl/apb_xfer_master.sv
module apb_xfer_master
    import apb_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_more,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              bus_sel,
    output logic              bus_enable,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err
);

    phase_e phase;
    logic   take;
    logic   chain_ok;

    apb_xfer_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .slv_ready (bus_ready),
        .chain_ok  (chain_ok),
        .phase     (phase),
        .take      (take),
        .req_ready (req_ready)
    );

    apb_xfer_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .take      (take),
        .slv_ready (bus_ready),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .req_more  (req_more),
        .bus_addr  (bus_addr),
        .bus_write (bus_write),
        .bus_wdata (bus_wdata),
        .chain_ok  (chain_ok)
    );

    apb_xfer_collect #(.DATA_W(DATA_W)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .slv_ready (bus_ready),
        .slv_rdata (bus_rdata),
        .slv_err   (bus_err),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    assign bus_sel    = (phase != PH_IDLE);
    assign bus_enable = (phase == PH_ACCESS);

endmodule

// File: rtl/apb_xfer_checker.sv
module apb_xfer_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              bus_sel,
    input logic              bus_enable,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_write,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic              rsp_done
);

    assert_setup_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_enable) |=> (bus_sel && bus_enable));

    assert_enable_with_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_enable |-> bus_sel);

    assert_hold_while_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_enable && !bus_ready) |=>
            (bus_sel && bus_enable && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (!bus_enable && !bus_write && bus_addr == '0 && bus_wdata == '0));

    assert_chain_to_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_enable && bus_ready && req_valid && req_ready) |=> (bus_sel && !bus_enable));

    assert_no_take_in_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_enable) |-> !req_ready);

    assert_done_follows_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_enable && bus_ready) |=> rsp_done);

    assert_done_only_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(bus_enable && bus_ready));

endmodule

bind apb_xfer_master apb_xfer_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .bus_sel    (bus_sel),
    .bus_enable (bus_enable),
    .bus_addr   (bus_addr),
    .bus_write  (bus_write),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .rsp_done   (rsp_done)
);

// File: tb/apb_xfer_master_bench.sv
module apb_xfer_master_bench;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_more = 1'b0;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_err;
    logic          bus_sel;
    logic          bus_enable;
    logic [AW-1:0] bus_addr;
    logic          bus_write;
    logic [DW-1:0] bus_wdata;
    logic          bus_ready = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_err = 1'b0;

    apb_xfer_master #(.ADDR_W(AW), .DATA_W(DW)) u_apb_xfer_master (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int bad = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    typedef struct {
        int unsigned addr;
        bit          wr;
        int unsigned wd;
        bit          more;
        int          waits;
        int          gap;
    } rq_t;

    rq_t q[$];

    // Behavioural reference: phase 0 idle, 1 setup, 2 access.
    int          ms = 0, ns = 0;
    int unsigned ma = 0, na = 0, mwd = 0, nwd = 0, mrd = 0, nrd = 0;
    bit          mw = 0, nw = 0, mmore = 0, nmore = 0;
    bit          mdone = 0, ndone = 0, merr = 0, nerr = 0;
    int          mwaits = 0, nwaits = 0, mwc = 0, nwc = 0;
    int          gapcnt = 0;
    int          cycles = 0;
    int          transfers = 0;

    function automatic int unsigned slave_data(int unsigned a);
        return (a * 32'h0001_0003) ^ 32'hC3A5_5A3C;
    endfunction

    function automatic void add(int unsigned a, bit w, int unsigned d, bit m, int wt, int g);
        rq_t r;
        r.addr = a; r.wr = w; r.wd = d; r.more = m; r.waits = wt; r.gap = g;
        q.push_back(r);
    endfunction

    initial begin
        bit rr, acc, comp;
        // Scenario list
        add(16'h0010, 1, 32'h1111_2222, 0, 0, 0);   // plain write, no wait
        add(16'h0024, 0, 32'h0,         0, 3, 2);   // read with waits
        add(16'h0030, 1, 32'hAAAA_0001, 1, 0, 0);   // chain, no waits
        add(16'h0034, 0, 32'h0,         1, 0, 0);
        add(16'h0038, 1, 32'hAAAA_0003, 0, 2, 0);
        add(16'h0040, 0, 32'h0,         0, 0, 0);   // unflagged then immediate next
        add(16'h0044, 1, 32'h5555_6666, 0, 1, 0);
        add(16'h004C, 0, 32'h0,         0, 20, 1);  // long wait, error address
        add(16'h0050, 1, 32'hBEEF_0001, 1, 1, 0);   // chain with waits
        add(16'h0058, 0, 32'h0,         1, 4, 0);
        add(16'h0060, 1, 32'hBEEF_0003, 0, 0, 0);
        add(16'h0070, 0, 32'h0,         1, 0, 0);   // flagged, successor late
        add(16'h0074, 1, 32'hFFFF_FFFF, 0, 0, 3);

        // Reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 sel",   {63'b0, bus_sel}, 64'd0);
        chk("R1 en",    {63'b0, bus_enable}, 64'd0);
        chk("R1 addr",  {48'b0, bus_addr}, 64'd0);
        chk("R1 wdata", {32'b0, bus_wdata}, 64'd0);
        chk("R1 write", {63'b0, bus_write}, 64'd0);
        chk("R1 done",  {63'b0, rsp_done}, 64'd0);
        chk("R1 ready", {63'b0, req_ready}, 64'd1);
        rst_n = 1'b1;

        while (cycles < 5000 && !(q.size() == 0 && ms == 0 && cycles > 10 && mwc > 5)) begin
            @(negedge clk);
            cycles++;
            // commit
            ms = ns; ma = na; mwd = nwd; mw = nw; mmore = nmore;
            mdone = ndone; mrd = nrd; merr = nerr; mwaits = nwaits; mwc = nwc;
            // compare
            chk(ms == 1 ? "R2 sel" : (ms == 2 ? "R3 sel" : "R4 sel"), {63'b0, bus_sel}, {63'b0, ms != 0});
            chk(ms == 1 ? "R2 enable" : "R3 enable", {63'b0, bus_enable}, {63'b0, ms == 2});
            chk(ms == 0 ? "R4 addr" : "R3 addr", {48'b0, bus_addr}, {48'b0, ma[15:0]});
            chk(ms == 0 ? "R4 write" : "R2 write", {63'b0, bus_write}, {63'b0, mw});
            chk(ms == 0 ? "R4 wdata" : "R3 wdata", {32'b0, bus_wdata}, {32'b0, mwd});
            chk("R7 done",  {63'b0, rsp_done}, {63'b0, mdone});
            chk("R7 rdata", {32'b0, rsp_rdata}, {32'b0, mrd});
            chk("R7 err",   {63'b0, rsp_err}, {63'b0, merr});
            // drive
            if (q.size() > 0 && gapcnt >= q[0].gap) begin
                req_valid = 1'b1;
                req_addr  = q[0].addr[15:0];
                req_write = q[0].wr;
                req_wdata = q[0].wd;
                req_more  = q[0].more;
            end else begin
                req_valid = 1'b0;
                req_addr  = 16'hDEAD;
                req_write = 1'b1;
                req_wdata = 32'h0BAD_F00D;
                req_more  = 1'b1;
            end
            if (ms == 2) begin
                bus_ready = (mwc >= mwaits);
                bus_rdata = slave_data(ma);
                bus_err   = ma[3];
            end else begin
                bus_ready = 1'b1;
                bus_rdata = 32'h1234_5678;
                bus_err   = 1'b1;
            end
            #1;
            rr = (ms == 0) || (ms == 2 && bus_ready && mmore);
            chk("R6 req_ready", {63'b0, req_ready}, {63'b0, rr});
            acc  = req_valid && rr;
            comp = (ms == 2) && bus_ready;
            // predict
            ndone = comp;
            nrd = comp ? bus_rdata : mrd;
            nerr = comp ? bus_err : merr;
            if (comp) transfers++;
            if (ms == 0)      ns = acc ? 1 : 0;
            else if (ms == 1) ns = 2;
            else              ns = !bus_ready ? 2 : (acc ? 1 : 0);
            if (acc) begin
                na = q[0].addr; nw = q[0].wr; nwd = q[0].wd; nmore = q[0].more;
                nwaits = q[0].waits; nwc = 0;
                void'(q.pop_front());
                gapcnt = 0;
            end else begin
                gapcnt++;
                if (comp) begin
                    na = 0; nw = 0; nwd = 0; nmore = 0;
                end
                nwc = mwc + 1;
            end
        end
        req_valid = 1'b0;
        if (cycles >= 5000) begin
            checks++; bad++;
            $display("FAIL watchdog R4 act=%0d exp<5000 cycles", cycles);
        end
        chk("R7 transfer count", 64'(transfers), 64'd13);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule